// File: doc/BRIEF.md
# Dual-Edge Programmable PWM Generator

The block drives a set of fan PWM outputs from one shared input clock. Three clock profiles (named M, N and O here) each run a free counter behind a two-stage prescaler. The first stage divides by an even step, or passes the clock through when its setting is zero. The second stage divides by a power of two. Each profile's counter cycles through a programmable period. Every output follows one profile, chosen by a two-bit type select whose two bits sit in separate places of the control register. The output goes high when its profile's counter reaches the output's rise point and low when the counter reaches its fall point.

Configuration is written through a single-cycle synchronous write port. Two outputs share each 32-bit duty register. Divider, period, duty and profile choices are held in shadow copies that reload only when the owning counter wraps, so a change never cuts a period short. A global run bit stops every counter at once. A per-output enable forces its pin low.

Top module: `dual_edge_pwm`

## Requirements
- R1: While reset is asserted and after it, until software writes the control register, every pwm_o bit is 0.
- R2: The counter of a profile counts 0..per, then wraps to 0, and advances once every lo_div*hi_div input cycles, where hi_div = 2^hdiv. The output period is lo_div*hi_div*(per+1) cycles.
- R3: The first prescaler stage divides by 1 when ldiv is 0 and by 2*ldiv otherwise.
- R4: The output goes high when the count reaches rise and low when it reaches fall. Its high time is ((fall-rise) mod (per+1)) counts.
- R5: When rise equals fall (including both 0), the enabled output stays high continuously.
- R6: Duty register at address 3+k serves outputs 2k and 2k+1. Output 2k takes its rise point from bits 7:0 and its fall point from bits 15:8. Output 2k+1 takes its rise point from bits 23:16 and its fall point from bits 31:24.
- R7: Control bit 8+i enables output i, and a disabled output is held low.
- R8: An output's type select takes bit 0 from control bit 12+i and bit 1 from control bit 4+i. Value 0 picks profile M, 1 picks N, and 2 or 3 picks O.
- R9: Control bit 0 is the global run bit. While it is 0, no counter or prescaler advances and every output holds its level. Counting resumes when it returns to 1.
- R10: New divider, period, duty and type settings take effect only at a wrap of the counter in use, so the period in progress finishes with its old settings.
- R11: Address 1 holds profile M in bits 15:0 and profile N in bits 31:16. Address 2 bits 15:0 hold profile O. In each 16-bit profile field, bits 3:0 are ldiv, bits 7:4 are hdiv and bits 15:8 are per.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared by all profiles |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Register address (0 control, 1 M/N clocks, 2 O clock, 3+k duty) |
| wr_data | input | 32 | Register write data |
| pwm_o | output | NUM_OUT | PWM outputs |

## Verification
The hardest situation to reach from the ports is a duty change that lands partway through a high pulse. In that case an immediate update would skip the fall point and stretch the pulse across the wrap. The stimulus first locks onto a rising edge of a 100-count period. It then waits a fixed number of cycles past the new, shorter fall point and rewrites the duty register. Finally it measures the rest of the current pulse and the whole of the next one.

// File: rtl/dual_edge_pwm_pkg.sv
package dual_edge_pwm_pkg;

    localparam int DIVW     = 4;   // width of each prescaler setting
    localparam int CNTW     = 8;   // width of period, rise and fall
    localparam int NUM_PROF = 3;   // profiles M, N, O
    localparam int REG_W    = 32;

    // control register bit positions
    localparam int RUN_BIT    = 0;
    localparam int TSEL1_BASE = 4;
    localparam int EN_BASE    = 8;
    localparam int TSEL0_BASE = 12;

    // register addresses
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_CLK_MN = 1;
    localparam int ADDR_CLK_O  = 2;
    localparam int ADDR_DUTY0  = 3;

    typedef struct packed {
        logic [CNTW-1:0] per;
        logic [DIVW-1:0] hdiv;
        logic [DIVW-1:0] ldiv;
    } prof_cfg_t;

    typedef struct packed {
        logic [CNTW-1:0] fall;
        logic [CNTW-1:0] rise;
    } edge_cfg_t;

    function automatic logic [1:0] prof_of_tsel(input logic [1:0] tsel);
        case (tsel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/dual_edge_pwm_regs.sv
module dual_edge_pwm_regs
    import dual_edge_pwm_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int ADDR_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [REG_W-1:0]                  wr_data,
    output logic                              run,
    output logic [NUM_OUT-1:0]                en,
    output logic [NUM_OUT-1:0][1:0]           tsel,
    output prof_cfg_t [NUM_PROF-1:0]          prof,
    output edge_cfg_t [NUM_OUT-1:0]           edges
);

    localparam int NUM_PAIR = NUM_OUT / 2;

    typedef struct packed {
        logic                              run;
        logic [NUM_OUT-1:0]                en;
        logic [NUM_OUT-1:0]                ts0;
        logic [NUM_OUT-1:0]                ts1;
        prof_cfg_t                         clk_m;
        prof_cfg_t                         clk_n;
        prof_cfg_t                         clk_o;
        logic [NUM_PAIR-1:0][REG_W-1:0]    duty;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
                r_d.run = wr_data[RUN_BIT];
                r_d.en  = wr_data[EN_BASE    +: NUM_OUT];
                r_d.ts0 = wr_data[TSEL0_BASE +: NUM_OUT];
                r_d.ts1 = wr_data[TSEL1_BASE +: NUM_OUT];
            end
            if (wr_addr == ADDR_W'(ADDR_CLK_MN)) begin
                r_d.clk_m = wr_data[15:0];
                r_d.clk_n = wr_data[31:16];
            end
            if (wr_addr == ADDR_W'(ADDR_CLK_O)) begin
                r_d.clk_o = wr_data[15:0];
            end
            for (int k = 0; k < NUM_PAIR; k++) begin
                if (wr_addr == ADDR_W'(ADDR_DUTY0 + k)) begin
                    r_d.duty[k] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run     = r_q.run;
    assign en      = r_q.en;
    assign prof[0] = r_q.clk_m;
    assign prof[1] = r_q.clk_n;
    assign prof[2] = r_q.clk_o;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign tsel[i] = {r_q.ts1[i], r_q.ts0[i]};
        if (i % 2 == 0) begin : g_lo
            assign edges[i] = r_q.duty[i/2][15:0];
        end else begin : g_hi
            assign edges[i] = r_q.duty[i/2][31:16];
        end
    end

endmodule

// File: rtl/dual_edge_pwm_timer.sv
module dual_edge_pwm_timer
    import dual_edge_pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  prof_cfg_t       cfg,
    output logic            step,
    output logic            wrap,
    output logic [CNTW-1:0] cnt_nxt,
    output logic [CNTW-1:0] cnt,
    output logic [CNTW-1:0] per
);

    localparam int LCW = DIVW + 1;          // holds 2*ldiv-1
    localparam int HCW = (1 << DIVW) - 1;   // holds 2^hdiv-1

    typedef struct packed {
        logic [LCW-1:0]  lo_cnt;
        logic [HCW-1:0]  hi_cnt;
        logic [CNTW-1:0] cnt;
        prof_cfg_t       sh;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [LCW-1:0] lo_lim;
    logic [HCW-1:0] hi_lim;

    always_comb begin
        lo_lim = (s_q.sh.ldiv == '0) ? '0 : LCW'({s_q.sh.ldiv, 1'b0} - 1'b1);
        hi_lim = HCW'((32'd1 << s_q.sh.hdiv) - 32'd1);
        s_d    = s_q;
        step   = 1'b0;
        wrap   = 1'b0;
        if (run) begin
            if (s_q.lo_cnt == lo_lim) begin
                s_d.lo_cnt = '0;
                if (s_q.hi_cnt == hi_lim) begin
                    s_d.hi_cnt = '0;
                    step       = 1'b1;
                end else begin
                    s_d.hi_cnt = s_q.hi_cnt + 1'b1;
                end
            end else begin
                s_d.lo_cnt = s_q.lo_cnt + 1'b1;
            end
        end
        if (step) begin
            if (s_q.cnt == s_q.sh.per) begin
                s_d.cnt = '0;
                s_d.sh  = cfg;
                wrap    = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_nxt = s_d.cnt;
    assign cnt     = s_q.cnt;
    assign per     = s_q.sh.per;

endmodule

// File: rtl/dual_edge_pwm_chan.sv
module dual_edge_pwm_chan
    import dual_edge_pwm_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [1:0]                      tsel,
    input  edge_cfg_t                       edges,
    input  logic [NUM_PROF-1:0]             step,
    input  logic [NUM_PROF-1:0]             wrap,
    input  logic [NUM_PROF-1:0][CNTW-1:0]   cnt_nxt,
    output logic                            pwm
);

    typedef struct packed {
        logic [1:0] sel;
        edge_cfg_t  sh;
        logic       level;
    } chan_t;

    chan_t c_d, c_q;
    logic [CNTW-1:0] nc;

    always_comb begin
        c_d = c_q;
        nc  = cnt_nxt[c_q.sel];
        if (step[c_q.sel]) begin
            if (wrap[c_q.sel]) begin
                c_d.sh  = edges;
                c_d.sel = prof_of_tsel(tsel);
            end
            if (nc == c_d.sh.rise) begin
                c_d.level = 1'b1;
            end else if (nc == c_d.sh.fall) begin
                c_d.level = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pwm = en & c_q.level;

endmodule

// File: rtl/dual_edge_pwm.sv
module dual_edge_pwm
    import dual_edge_pwm_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    output logic [NUM_OUT-1:0] pwm_o
);

    logic                            run_w;
    logic [NUM_OUT-1:0]              en_w;
    logic [NUM_OUT-1:0][1:0]         tsel_w;
    prof_cfg_t [NUM_PROF-1:0]        prof_w;
    edge_cfg_t [NUM_OUT-1:0]         edges_w;
    logic [NUM_PROF-1:0]             step_w;
    logic [NUM_PROF-1:0]             wrap_w;
    logic [NUM_PROF-1:0][CNTW-1:0]   nxt_w;
    logic [NUM_PROF-1:0][CNTW-1:0]   prof_cnt;
    logic [NUM_PROF-1:0][CNTW-1:0]   prof_per;

    dual_edge_pwm_regs #(
        .NUM_OUT (NUM_OUT),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .run     (run_w),
        .en      (en_w),
        .tsel    (tsel_w),
        .prof    (prof_w),
        .edges   (edges_w)
    );

    for (genvar p = 0; p < NUM_PROF; p++) begin : g_prof
        dual_edge_pwm_timer u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_w),
            .cfg     (prof_w[p]),
            .step    (step_w[p]),
            .wrap    (wrap_w[p]),
            .cnt_nxt (nxt_w[p]),
            .cnt     (prof_cnt[p]),
            .per     (prof_per[p])
        );
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
        dual_edge_pwm_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_w[i]),
            .tsel    (tsel_w[i]),
            .edges   (edges_w[i]),
            .step    (step_w),
            .wrap    (wrap_w),
            .cnt_nxt (nxt_w),
            .pwm     (pwm_o[i])
        );
    end

endmodule

// File: rtl/dual_edge_pwm_chk.sv
module dual_edge_pwm_chk
    import dual_edge_pwm_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            run,
    input logic [NUM_OUT-1:0]              en,
    input logic [NUM_OUT-1:0]              pwm,
    input logic [NUM_PROF-1:0][CNTW-1:0]   cnt,
    input logic [NUM_PROF-1:0][CNTW-1:0]   per
);

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm & ~en) == '0);  // R7

    for (genvar p = 0; p < NUM_PROF; p++) begin : g_p
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[p] <= per[p]);  // R2

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[p] != $past(cnt[p])) |-> (cnt[p] == 0 || cnt[p] == $past(cnt[p]) + 1'b1));  // R2

        AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> $stable(cnt[p]));  // R9
    end

endmodule

bind dual_edge_pwm dual_edge_pwm_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .en    (en_w),
    .pwm   (pwm_o),
    .cnt   (prof_cnt),
    .per   (prof_per)
);

// File: tb/sim_dual_edge_pwm.sv
module sim_dual_edge_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int NOUT       = 4;
    localparam int AW         = 3;
    localparam int TMO        = 20000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [NOUT-1:0] pwm_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    dual_edge_pwm #(.NUM_OUT(NOUT), .ADDR_W(AW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [15:0] ph(input int per, input int hdiv, input int ldiv);
        return {8'(per), 4'(hdiv), 4'(ldiv)};
    endfunction

    function automatic logic [31:0] ctl(input bit run, input logic [3:0] en,
                                        input logic [1:0] t0, input logic [1:0] t1,
                                        input logic [1:0] t2, input logic [1:0] t3);
        logic [31:0] v;
        logic [3:0]  b0, b1;
        b0 = {t3[0], t2[0], t1[0], t0[0]};
        b1 = {t3[1], t2[1], t1[1], t0[1]};
        v = '0;
        v[0]     = run;
        v[11:8]  = en;
        v[15:12] = b0;
        v[7:4]   = b1;
        return v;
    endfunction

    // high samples of one pulse and cycles from that rise to the next
    task automatic measure(input int idx, output int hi_t, output int per_t);
        int t;
        t = 0;
        @(negedge clk);
        while (pwm_o[idx] == 1'b1 && t < TMO) begin @(negedge clk); t++; end
        while (pwm_o[idx] == 1'b0 && t < TMO) begin @(negedge clk); t++; end
        hi_t = 0;
        while (pwm_o[idx] == 1'b1 && t < TMO) begin hi_t++; @(negedge clk); t++; end
        per_t = hi_t;
        while (pwm_o[idx] == 1'b0 && t < TMO) begin per_t++; @(negedge clk); t++; end
    endtask

    task automatic settle_measure(input int idx, output int hi_t, output int per_t);
        int h, p;
        measure(idx, h, p);
        measure(idx, hi_t, per_t);
    endtask

    // number of cycles in a window with the output at the given level
    task automatic count_level(input int idx, input int cycles, input bit lvl, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pwm_o[idx] == lvl) n++;
        end
    endtask

    task automatic t_reset;
        chk("R1 pwm in reset", int'(pwm_o), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 pwm after reset", int'(pwm_o), 0);
    endtask

    task automatic t_basic;
        int h, p;
        wr(1, {16'h0, ph(9, 0, 0)});
        wr(3, {16'h0, 8'd7, 8'd2});
        wr(0, ctl(1, 4'b0001, 0, 0, 0, 0));
        settle_measure(0, h, p);
        chk("R4 high time rise2 fall7", h, 5);
        chk("R2 period per9", p, 10);
        wr(3, {16'h0, 8'd2, 8'd7});     // fall before rise: wraps around
        settle_measure(0, h, p);
        chk("R4 high time rise7 fall2", h, 5);
        chk("R11 period field", p, 10);
    endtask

    task automatic t_lodiv;
        int h, p;
        wr(1, {16'h0, ph(4, 0, 3)});
        wr(3, {16'h0, 8'd2, 8'd0});
        settle_measure(0, h, p);
        chk("R3 ldiv3 period", p, 30);
        chk("R3 ldiv3 high", h, 12);
    endtask

    task automatic t_hidiv;
        int h, p;
        wr(1, {16'h0, ph(3, 2, 1)});
        wr(3, {16'h0, 8'd3, 8'd1});
        settle_measure(0, h, p);
        chk("R2 hdiv2 ldiv1 period", p, 32);
        chk("R2 hdiv2 ldiv1 high", h, 16);
    endtask

    task automatic t_full;
        int n, h, p;
        wr(1, {16'h0, ph(9, 0, 0)});
        wr(3, {16'h0, 8'd0, 8'd0});
        repeat (30) @(negedge clk);
        count_level(0, 200, 1'b1, n);
        chk("R5 rise0 fall0 constant high", n, 200);
        wr(3, {16'h0, 8'd3, 8'd3});
        repeat (30) @(negedge clk);
        count_level(0, 200, 1'b1, n);
        chk("R5 rise3 fall3 constant high", n, 200);
        wr(3, {16'h0, 8'd7, 8'd2});
        settle_measure(0, h, p);
    endtask

    task automatic t_pair;
        int h, p;
        wr(3, {8'd6, 8'd1, 8'd4, 8'd0});
        wr(0, ctl(1, 4'b0011, 0, 0, 0, 0));
        settle_measure(1, h, p);
        chk("R6 upper half high", h, 5);
        chk("R6 upper half period", p, 10);
        settle_measure(0, h, p);
        chk("R6 lower half high", h, 4);
    endtask

    task automatic t_type;
        int h, p;
        wr(1, {ph(19, 0, 0), ph(9, 0, 0)});
        wr(2, {16'h0, ph(14, 0, 1)});
        wr(4, {8'd5, 8'd0, 8'd4, 8'd0});
        wr(0, ctl(1, 4'b1111, 0, 0, 2'd1, 2'd2));
        settle_measure(2, h, p);
        chk("R8 tsel1 picks N period", p, 20);
        chk("R8 tsel1 picks N high", h, 4);
        settle_measure(3, h, p);
        chk("R8 tsel2 picks O period", p, 30);
        chk("R8 tsel2 picks O high", h, 10);
        wr(0, ctl(1, 4'b1111, 0, 0, 2'd1, 2'd3));
        settle_measure(3, h, p);
        chk("R8 tsel3 picks O period", p, 30);
        wr(0, ctl(1, 4'b1111, 0, 0, 2'd0, 2'd2));
        settle_measure(2, h, p);
        chk("R8 tsel0 picks M period", p, 10);
    endtask

    task automatic t_enable;
        int n;
        wr(0, ctl(1, 4'b1110, 0, 0, 0, 2'd2));
        count_level(0, 100, 1'b0, n);
        chk("R7 disabled output low", n, 100);
        count_level(1, 100, 1'b1, n);
        chk("R7 neighbour still toggles", int'(n > 0 && n < 100), 1);
    endtask

    task automatic t_run;
        int n, h, p;
        logic lvl;
        wr(0, ctl(1, 4'b0001, 0, 0, 0, 0));
        wr(3, {16'h0, 8'd7, 8'd2});
        settle_measure(0, h, p);
        repeat (3) @(negedge clk);
        wr(0, ctl(0, 4'b0001, 0, 0, 0, 0));
        @(negedge clk);
        lvl = pwm_o[0];
        count_level(0, 100, lvl, n);
        chk("R9 output frozen when stopped", n, 100);
        wr(0, ctl(1, 4'b0001, 0, 0, 0, 0));
        settle_measure(0, h, p);
        chk("R9 resume period", p, 10);
    endtask

    task automatic t_update;
        int h, p, c, t;
        wr(1, {16'h0, ph(99, 0, 0)});
        wr(3, {16'h0, 8'd60, 8'd0});
        settle_measure(0, h, p);
        chk("R10 old duty high", h, 60);
        t = 0;
        while (pwm_o[0] == 1'b1 && t < TMO) begin @(negedge clk); t++; end
        while (pwm_o[0] == 1'b0 && t < TMO) begin @(negedge clk); t++; end
        repeat (45) @(negedge clk);
        wr(3, {16'h0, 8'd30, 8'd0});
        c = 0;
        while (pwm_o[0] == 1'b1 && c < TMO) begin c++; @(negedge clk); end
        chk("R10 current pulse not stretched", int'(c <= 60), 1);
        measure(0, h, p);
        chk("R10 next pulse new high", h, 30);
        chk("R10 next pulse period", p, 100);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset;
        t_basic;
        t_lodiv;
        t_hidiv;
        t_full;
        t_pair;
        t_type;
        t_enable;
        t_run;
        t_update;
        summary;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
        $finish;
    end

endmodule